// File: doc/BRIEF.md
# Interrupt Status, Mask and Receive Coalescing Unit

This block gathers eight single-cycle event pulses from a network controller into a sticky status register. It compares that register against an enable mask and drives one level interrupt toward the host whenever an enabled bit is pending. Software acknowledges an event by writing 1 to its status bit.

The receive event does not reach its status bit directly. It passes through a coalescer, which counts received frames and raises the receive bit once per batch of 1, 2, 4 or 8 frames. A 16-bit hold-off timer limits how long a partly filled batch can wait. When the timer runs out with frames still uncounted, the receive bit is raised and the batch restarts.

All configuration and status is reached through a byte-wide register port. Writes are strobed, and reads are combinational on the address.

Top module: `irq_coalesce_unit`

## Requirements
- R1: Status bit positions are: 0 fragment counter, 1 receive, 2 transmit, 3 receive error, 4 transmit error, 5 FIFO error, 6 bus error, 7 receive-buffer-full. A pulse on any non-receive event input sets its own status bit at the clock edge that samples the pulse.
- R2: `irq` is high exactly when some bit is set in both status and mask. Mask is at address 1.
- R3: A write to status (address 0) clears every bit written as 1 and leaves bits written as 0 unchanged.
- R4: If an event sets a status bit in the same cycle that a write-1 clears that bit, the bit stays set.
- R5: The selector in control bits [1:0] (address 2) sets the batch size: 00 gives 1 frame, 01 gives 2, 10 gives 4, 11 gives 8. The receive status bit is set at the edge that samples the frame completing the batch, not before.
- R6: With a non-zero hold-off value T, the first uncounted frame loads the timer. The timer counts down once per clock. The receive bit is set T clocks after that frame is sampled, and the frame count is cleared, so a full new batch is needed for the next count-based raise.
- R7: A hold-off value of zero disables the timer, so only the frame count raises the receive bit.
- R8: After reset, status, mask, control selector and hold-off value all read 00h and `irq` is low.
- R9: The hold-off value is at address 3 (low byte) and address 4 (high byte). Control reads back only bits [1:0]. Addresses 5 to 7 read 00h, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 8 | Single-cycle event pulses, bit layout as R1 (bit 1 = received frame) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on reg_addr |
| irq | output | 1 | Interrupt line, high while an enabled status bit is set |

## Verification
The coalescer is driven with frame trains one short of each batch size and then exactly at it. This separates a correct threshold from an off-by-one. A single frame under a hold-off value is checked one clock before and at the expected expiry edge, and a later frame train confirms the count was cleared. A zero hold-off with a long idle gap shows that the timer really is disabled. Simultaneous clear and event, mixed 1/0 clear patterns, and masked versus unmasked pending bits separate the priority, clear and mask paths.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;
  localparam int NUM_EVT  = 8;
  localparam int ADDR_W   = 3;
  localparam int B_FRAG   = 0;
  localparam int B_RX     = 1;
  localparam int B_TX     = 2;
  localparam int B_RXERR  = 3;
  localparam int B_TXERR  = 4;
  localparam int B_FIFO   = 5;
  localparam int B_BUS    = 6;
  localparam int B_RXFULL = 7;

  typedef enum logic [ADDR_W-1:0] {
    A_STATUS = 3'd0,
    A_MASK   = 3'd1,
    A_CTRL   = 3'd2,
    A_TMR_LO = 3'd3,
    A_TMR_HI = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] status
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic bit_d;
    logic bit_en;

    always_comb begin
      bit_en = set_vec[i] | clr_vec[i];
      bit_d  = set_vec[i];           // set outranks clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      status[i] <= 1'b0;
      else if (bit_en) status[i] <= bit_d;
    end
  end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_coal_pkg::*;
#(
  parameter int SEL_W = 2,
  parameter int TMR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [NUM_EVT-1:0] mask_q,
  output logic [SEL_W-1:0]  sel_q,
  output logic [TMR_W-1:0]  tmr_q
);
  logic we_mask, we_ctrl, we_lo, we_hi;

  always_comb begin
    we_mask = wr && (addr == A_MASK);
    we_ctrl = wr && (addr == A_CTRL);
    we_lo   = wr && (addr == A_TMR_LO);
    we_hi   = wr && (addr == A_TMR_HI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (we_mask) mask_q <= wdata[NUM_EVT-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sel_q <= '0;
    else if (we_ctrl) sel_q <= wdata[SEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tmr_q[7:0] <= '0;
    else if (we_lo) tmr_q[7:0] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tmr_q[TMR_W-1:8] <= '0;
    else if (we_hi) tmr_q[TMR_W-1:8] <= wdata[TMR_W-9:0];
  end
endmodule

// File: rtl/irq_rx_coalescer.sv
module irq_rx_coalescer #(
  parameter int SEL_W = 2,
  parameter int TMR_W = 16,
  localparam int CNT_W = 2**SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame,
  input  logic [SEL_W-1:0] sel,
  input  logic [TMR_W-1:0] tmr_val,
  output logic             raise,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, base_cnt, inc_cnt, thr;
  logic [TMR_W-1:0] hold_q, hold_d, hold_dec;
  logic             expire, hit;

  always_comb begin
    thr      = CNT_W'(1) << sel;
    expire   = (hold_q == TMR_W'(1));
    hold_dec = (hold_q != '0) ? hold_q - TMR_W'(1) : '0;
    base_cnt = expire ? '0 : cnt_q;
    inc_cnt  = base_cnt + CNT_W'(1);
    hit      = frame && (inc_cnt >= thr);
    cnt_d    = base_cnt;
    hold_d   = hold_dec;
    if (frame) begin
      if (hit) begin
        cnt_d  = '0;
        hold_d = '0;
      end else begin
        cnt_d = inc_cnt;
        if (base_cnt == '0) hold_d = tmr_val;   // first uncounted frame
      end
    end
    raise = expire | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/irq_coalesce_unit.sv
module irq_coalesce_unit
  import irq_coal_pkg::*;
#(
  parameter int SEL_W = 2,
  parameter int TMR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  output logic               irq
);
  localparam int CNT_W = 2**SEL_W;

  logic [NUM_EVT-1:0] status_q, mask_q, ev_set, clr_vec;
  logic [SEL_W-1:0]   ctrl_sel;
  logic [TMR_W-1:0]   tmr_val;
  logic               rx_raise;
  logic [CNT_W-1:0]   frm_cnt;

  irq_cfg_regs #(.SEL_W(SEL_W), .TMR_W(TMR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .mask_q(mask_q), .sel_q(ctrl_sel), .tmr_q(tmr_val)
  );

  irq_rx_coalescer #(.SEL_W(SEL_W), .TMR_W(TMR_W)) u_coal (
    .clk(clk), .rst_n(rst_n), .frame(evt_pulse[B_RX]), .sel(ctrl_sel),
    .tmr_val(tmr_val), .raise(rx_raise), .cnt_o(frm_cnt)
  );

  always_comb begin
    ev_set       = evt_pulse;
    ev_set[B_RX] = rx_raise;
    clr_vec      = (reg_wr && reg_addr == A_STATUS) ? reg_wdata[NUM_EVT-1:0] : '0;
  end

  irq_status_bank #(.N(NUM_EVT)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_vec(ev_set), .clr_vec(clr_vec), .status(status_q)
  );

  always_comb begin
    unique case (reg_addr)
      A_STATUS: reg_rdata = 8'(status_q);
      A_MASK:   reg_rdata = 8'(mask_q);
      A_CTRL:   reg_rdata = 8'(ctrl_sel);
      A_TMR_LO: reg_rdata = tmr_val[7:0];
      A_TMR_HI: reg_rdata = 8'(tmr_val[TMR_W-1:8]);
      default:  reg_rdata = 8'h00;
    endcase
  end

  assign irq = |(status_q & mask_q);
endmodule

// File: rtl/irq_coalesce_unit_chk.sv
module irq_coalesce_unit_chk
  import irq_coal_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_EVT-1:0] evt_pulse,
  input logic               reg_wr,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [7:0]         reg_wdata,
  input logic               irq,
  input logic [NUM_EVT-1:0] status_q,
  input logic [NUM_EVT-1:0] ev_set,
  input logic [SEL_W-1:0]   ctrl_sel
);
  p_nonrx_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse[B_TX] |=> status_q[B_TX]);

  p_mask_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_MASK && reg_wdata == 8'h00) |=> !irq);

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_STATUS) |=>
      ((status_q & $past(reg_wdata[NUM_EVT-1:0]) & ~$past(ev_set)) == '0));

  p_event_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_set) |=> ((status_q & $past(ev_set)) == $past(ev_set)));

  p_single_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_sel == '0 && evt_pulse[B_RX]) |=> status_q[B_RX]);
endmodule

bind irq_coalesce_unit irq_coalesce_unit_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq(irq),
  .status_q(status_q), .ev_set(ev_set), .ctrl_sel(ctrl_sel)
);

// File: tb/irq_coalesce_unit_tb.sv
`timescale 1ns/1ps
module irq_coalesce_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] evt_pulse;
  logic       reg_wr;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  irq_coalesce_unit u_dut (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [7:0] v);
    @(negedge clk);
    evt_pulse = v;
    @(negedge clk);
    evt_pulse = 8'h00;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset_r8();
    logic [7:0] d;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      chk($sformatf("R8 reset addr %0d", a), d, 0);
    end
    chk("R8 irq after reset", irq, 0);
  endtask

  task automatic t_events_r1();
    logic [7:0] d;
    pulse(8'h01); rd(3'd0, d); chk("R1 fragment bit0", d, 8'h01);
    pulse(8'h80); rd(3'd0, d); chk("R1 rx-full bit7", d, 8'h81);
    pulse(8'h7C); rd(3'd0, d); chk("R1 bits2..6", d, 8'hFD);
    wr(3'd0, 8'hFF); rd(3'd0, d); chk("R1 cleared", d, 8'h00);
  endtask

  task automatic t_mask_r2();
    logic [7:0] d;
    wr(3'd1, 8'h04);
    pulse(8'h08); chk("R2 masked pending gives no irq", irq, 0);
    pulse(8'h04); chk("R2 enabled pending raises irq", irq, 1);
    rd(3'd1, d);  chk("R2 mask readback", d, 8'h04);
    wr(3'd1, 8'h00); chk("R2 mask cleared drops irq", irq, 0);
    wr(3'd0, 8'hFF);
  endtask

  task automatic t_w1c_r3();
    logic [7:0] d;
    pulse(8'h85);
    wr(3'd0, 8'h05); rd(3'd0, d); chk("R3 partial clear", d, 8'h80);
    wr(3'd0, 8'h00); rd(3'd0, d); chk("R3 zero write keeps", d, 8'h80);
    wr(3'd0, 8'h80); rd(3'd0, d); chk("R3 final clear", d, 8'h00);
  endtask

  task automatic t_priority_r4();
    logic [7:0] d;
    pulse(8'h0C);
    @(negedge clk);
    reg_addr = 3'd0; reg_wdata = 8'h0C; reg_wr = 1'b1; evt_pulse = 8'h04;
    @(negedge clk);
    reg_wr = 1'b0; evt_pulse = 8'h00;
    rd(3'd0, d); chk("R4 event beats clear", d, 8'h04);
    wr(3'd0, 8'hFF);
  endtask

  task automatic t_count_r5();
    logic [7:0] d;
    for (int s = 0; s < 4; s++) begin
      int n;
      n = 1 << s;
      wr(3'd2, 8'(s));
      wr(3'd0, 8'hFF);
      for (int k = 0; k < n - 1; k++) pulse(8'h02);
      rd(3'd0, d);
      chk($sformatf("R5 sel %0d below batch", s), d, 8'h00);
      pulse(8'h02);
      rd(3'd0, d);
      chk($sformatf("R5 sel %0d at batch", s), d, 8'h02);
    end
    wr(3'd0, 8'hFF);
  endtask

  task automatic t_timer_off_r7();
    logic [7:0] d;
    wr(3'd2, 8'h03);
    pulse(8'h02);
    idle(60);
    rd(3'd0, d); chk("R7 zero timer never expires", d, 8'h00);
    for (int k = 0; k < 7; k++) pulse(8'h02);
    rd(3'd0, d); chk("R7 count still raises", d, 8'h02);
    wr(3'd0, 8'hFF);
  endtask

  task automatic t_timer_r6();
    logic [7:0] d;
    wr(3'd2, 8'h02);
    wr(3'd3, 8'h05);
    pulse(8'h02);
    idle(3);
    rd(3'd0, d); chk("R6 before expiry", d, 8'h00);
    idle(1);
    rd(3'd0, d); chk("R6 one clock before expiry", d, 8'h00);
    idle(1);
    rd(3'd0, d); chk("R6 at expiry", d, 8'h02);
    wr(3'd3, 8'h00);
    wr(3'd0, 8'hFF);
    for (int k = 0; k < 3; k++) pulse(8'h02);
    rd(3'd0, d); chk("R6 count cleared by expiry", d, 8'h00);
    pulse(8'h02);
    rd(3'd0, d); chk("R6 fresh batch raises", d, 8'h02);
    wr(3'd0, 8'hFF);
  endtask

  task automatic t_regmap_r9();
    logic [7:0] d;
    wr(3'd2, 8'hFF); rd(3'd2, d); chk("R9 ctrl width", d, 8'h03);
    wr(3'd3, 8'h34); wr(3'd4, 8'h12);
    rd(3'd3, d); chk("R9 timer low", d, 8'h34);
    rd(3'd4, d); chk("R9 timer high", d, 8'h12);
    wr(3'd1, 8'h5A);
    wr(3'd6, 8'hFF);
    rd(3'd6, d); chk("R9 unused reads zero", d, 8'h00);
    rd(3'd1, d); chk("R9 unused write leaves mask", d, 8'h5A);
    rd(3'd0, d); chk("R9 unused write leaves status", d, 8'h00);
    rd(3'd5, d); chk("R9 addr5 reads zero", d, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; evt_pulse = 8'h00; reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = 8'h00;
    idle(4);
    t_reset_r8();
    rst_n = 1'b1;
    idle(2);
    t_events_r1();
    t_mask_r2();
    t_w1c_r3();
    t_priority_r4();
    t_count_r5();
    t_timer_off_r7();
    t_timer_r6();
    t_regmap_r9();
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule